// File: doc/BRIEF.md
# Synchronous Clock Output Stop Controller

This block decides, cycle by cycle, whether each of eight generated clock outputs runs, parks high or parks low, and it drives the resulting true/complement pair. Every channel divides the undivided master clock by its own ratio. Each channel then changes its gate state only on one of its own divider edges, so no output ever shows a shortened or lengthened pulse. The stop sources are two active-low group stop inputs and three active-low clock-request inputs. Per-channel output-enable and stoppable bits, and a six-bit request routing field, set how those sources act on each channel.

Channel indices are fixed: 0 and 1 are CPU outputs, 2 is the shared CPU/SRC output, 3 to 5 are SRC0 to SRC2, 6 is PCI0 and 7 is the free-running PCI output. Channels 0 to 5 are differential. Channels 6 and 7 are single-ended, and their complement pin is held at 0. A strap input decides whether channel 2 belongs to the CPU group or to the SRC group. The stop inputs and request inputs are brought into the master clock domain by a two-stage synchronizer before they take effect.

Top module: `clk_stop_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every clkTrue and clkComp bit is 0.
- R2: A running channel toggles clkTrue with high and low phases of exactly DIV master cycles each. The divisors are CPU_DIV for channels 0 and 1, SHARED_DIV for channel 2, SRC_DIV for channels 3 to 5 and PCI_DIV for channels 6 and 7. On differential channels 0 to 5, clkComp is the inverse of clkTrue; on channels 6 and 7 it stays 0.
- R3: clkTrue changes only on the channel's own divider edge, and no level segment is shorter than DIV master cycles. This holds through every start, stop, enable and disable.
- R4: When cpuStopN is low, every enabled CPU-group channel whose stopAllowed bit is 1 parks with clkTrue=1 and clkComp=0 within SYNC_STAGES+2*DIV cycles. The CPU group is channels 0 and 1, plus channel 2 when sharedIsCpu=1.
- R5: When pciSrcStopN is low, the enabled stoppable SRC-group channels park with clkTrue=1 and clkComp=0, and the stoppable channels 6 and 7 park low. The SRC group is channels 3 to 5, plus channel 2 when sharedIsCpu=0. CPU-group channels keep running.
- R6: Once every stop cause is removed, a parked channel runs again within SYNC_STAGES+2*DIV cycles, and its first pulse has full width.
- R7: outEnable[i]=0 drives both clkTrue[i] and clkComp[i] low, whatever the stop and request inputs are.
- R8: reqRoute bit 0 routes clkReqN[0] to SRC0 and bit 1 routes it to SRC1. Bit 2 routes clkReqN[1] to SRC0 and bit 3 routes it to SRC2. Bit 4 routes clkReqN[2] to SRC2 and bit 5 routes it to channel 2. A low request input parks every channel it is routed to (true high, complement low), whatever stopAllowed says. A request input that is not routed to a channel has no effect on it.
- R9: With sharedIsCpu=1, channel 2 follows cpuStopN only, and clkReqN and pciSrcStopN do not affect it. With sharedIsCpu=0 it follows pciSrcStopN and the bit-5 request route.
- R10: A channel whose stopAllowed bit is 0 keeps running while either stop input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuStopN | input | 1 | Active-low stop for the CPU group |
| pciSrcStopN | input | 1 | Active-low stop for the SRC and PCI groups |
| clkReqN | input | 3 | Active-low clock-request inputs |
| sharedIsCpu | input | 1 | 1: channel 2 is in the CPU group; 0: SRC group |
| outEnable | input | 8 | Per-channel output enable |
| stopAllowed | input | 8 | Per-channel stoppable (1) or free-running (0) |
| reqRoute | input | 6 | Request-to-channel routing bits (see R8) |
| clkTrue | output | 8 | True clock output per channel |
| clkComp | output | 8 | Complement clock output per channel |

## Verification
The bench applies a sequence of input settings and classifies every channel over a window as running, parked high or parked low. The settings are: all outputs free running; each group stop alone with all channels stoppable; both stops with nothing stoppable; a checkerboard of disabled channels combined with active stops; single routed and unrouted request inputs; and both settings of the shared-channel strap. Together these separate the group membership of every channel, the priority of disable over stop, the independence of requests from the stoppable bits, and the strap's effect on channel 2. A separate monitor measures every clkTrue segment against the channel's divisor. This catches runt pulses at each start and stop.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  localparam int NCH    = 8;
  localparam int NREQ   = 3;
  localparam int NROUTE = 6;

  localparam int CH_CPU0   = 0;
  localparam int CH_CPU1   = 1;
  localparam int CH_SHARED = 2;
  localparam int CH_SRC0   = 3;
  localparam int CH_SRC1   = 4;
  localparam int CH_SRC2   = 5;
  localparam int CH_PCI0   = 6;
  localparam int CH_PCIF   = 7;

  localparam logic [NCH-1:0] DIFF_MASK = 8'b0011_1111;

  localparam int RT_R1_SRC0   = 0;
  localparam int RT_R1_SRC1   = 1;
  localparam int RT_R2_SRC0   = 2;
  localparam int RT_R2_SRC2   = 3;
  localparam int RT_R3_SRC2   = 4;
  localparam int RT_R3_SHARED = 5;

  typedef enum logic [1:0] {
    GM_RUN     = 2'd0,
    GM_PARK_HI = 2'd1,
    GM_PARK_LO = 2'd2
  } gate_mode_e;

  typedef struct packed {
    logic [NCH-1:0] runReq;
    logic [NCH-1:0] parkHiReq;
  } gate_cmd_t;
endpackage

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuStopN,
  input  logic              pciSrcStopN,
  input  logic [NREQ-1:0]   clkReqN,
  input  logic              sharedIsCpu,
  input  logic [NCH-1:0]    outEnable,
  input  logic [NCH-1:0]    stopAllowed,
  input  logic [NROUTE-1:0] reqRoute,
  output gate_cmd_t         cmd
);
  localparam int NIN = 2 + NREQ;

  logic [NIN-1:0]  rawN;
  logic [NIN-1:0]  syncN;
  logic [NREQ-1:0] reqOn;
  logic [NCH-1:0]  reqHit;
  logic [NCH-1:0]  stopNow;
  logic            cpuStop;
  logic            srcStop;

  assign rawN = {clkReqN, pciSrcStopN, cpuStopN};

  for (genvar si = 0; si < NIN; si++) begin : g_sync
    logic [SYNC_STAGES-1:0] sr;
    always_ff @(posedge clk) begin
      if (!rst_n) sr <= '1;
      else        sr <= {sr[SYNC_STAGES-2:0], rawN[si]};
    end
    assign syncN[si] = sr[SYNC_STAGES-1];
  end

  always_comb begin
    cpuStop = ~syncN[0];
    srcStop = ~syncN[1];
    reqOn   = ~syncN[NIN-1:2];

    reqHit            = '0;
    reqHit[CH_SRC0]   = (reqRoute[RT_R1_SRC0] & reqOn[0]) | (reqRoute[RT_R2_SRC0] & reqOn[1]);
    reqHit[CH_SRC1]   = reqRoute[RT_R1_SRC1] & reqOn[0];
    reqHit[CH_SRC2]   = (reqRoute[RT_R2_SRC2] & reqOn[1]) | (reqRoute[RT_R3_SRC2] & reqOn[2]);
    reqHit[CH_SHARED] = ~sharedIsCpu & reqRoute[RT_R3_SHARED] & reqOn[2];

    for (int ch = 0; ch < NCH; ch++) begin
      logic inCpu;
      inCpu = (ch == CH_CPU0) || (ch == CH_CPU1) || ((ch == CH_SHARED) && sharedIsCpu);
      stopNow[ch]       = ((inCpu ? cpuStop : srcStop) & stopAllowed[ch]) | reqHit[ch];
      cmd.runReq[ch]    = outEnable[ch] & ~stopNow[ch];
      cmd.parkHiReq[ch] = outEnable[ch] & stopNow[ch];
    end
  end

  // R10: a free-running enabled CPU channel is always asked to run
  p_free_cpu_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (outEnable[CH_CPU0] && !stopAllowed[CH_CPU0]) |-> cmd.runReq[CH_CPU0]);

  // R9: shared channel in CPU mode ignores requests and SRC stop
  p_shared_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sharedIsCpu && outEnable[CH_SHARED] && syncN[0]) |-> cmd.runReq[CH_SHARED]);

  // R8: a routed, asserted request parks SRC0 high
  p_req_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqRoute[RT_R1_SRC0] && reqOn[0] && outEnable[CH_SRC0]) |-> cmd.parkHiReq[CH_SRC0]);
endmodule

// File: rtl/clk_stop_chan.sv
module clk_stop_chan
  import clk_stop_pkg::*;
#(
  parameter int DIV  = 4,
  parameter bit DIFF = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic runReq,
  input  logic parkHiReq,
  output logic outTrue,
  output logic outComp
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          ph;
  logic          atEdge;
  logic          newPh;
  logic          wantLvl;
  gate_mode_e    mode;
  gate_mode_e    modeWant;
  gate_mode_e    modeNxt;

  assign outTrue = (mode == GM_RUN) ? ph : (mode == GM_PARK_HI);
  assign outComp = DIFF && (mode == GM_RUN) && !ph;

  always_comb begin
    atEdge = (cnt == CW'(DIV - 1));
    newPh  = ~ph;
    if (runReq)                 modeWant = GM_RUN;
    else if (parkHiReq && DIFF) modeWant = GM_PARK_HI;
    else                        modeWant = GM_PARK_LO;
    case (modeWant)
      GM_RUN:     wantLvl = newPh;
      GM_PARK_HI: wantLvl = 1'b1;
      default:    wantLvl = 1'b0;
    endcase
    // switch only when the output completes a whole phase here
    modeNxt = mode;
    if ((wantLvl == newPh) && (outTrue == ph)) modeNxt = modeWant;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      ph   <= 1'b0;
      mode <= GM_PARK_LO;
    end else if (atEdge) begin
      cnt  <= '0;
      ph   <= newPh;
      mode <= modeNxt;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // segment length tracking for the pulse-width property
  logic        prevOut;
  logic [15:0] segLen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevOut <= 1'b0;
      segLen  <= '0;
    end else begin
      prevOut <= outTrue;
      if (outTrue != prevOut)  segLen <= 16'd1;
      else if (segLen != '1)   segLen <= segLen + 1'b1;
    end
  end

  // R3: no level segment shorter than the channel divisor
  p_min_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outTrue != prevOut) |-> (segLen >= 16'(DIV)));

  // R3: output moves only on the channel's own divider edge
  p_edge_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outTrue != $past(outTrue)) |-> $past(atEdge));

  // R2: true and complement are never high together
  p_comp_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(outTrue && outComp));
endmodule

// File: rtl/clk_stop_dpath.sv
module clk_stop_dpath
  import clk_stop_pkg::*;
#(
  parameter int CPU_DIV    = 3,
  parameter int SHARED_DIV = 4,
  parameter int SRC_DIV    = 4,
  parameter int PCI_DIV    = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  gate_cmd_t      cmd,
  output logic [NCH-1:0] clkTrue,
  output logic [NCH-1:0] clkComp
);
  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    localparam int D = (gi == CH_CPU0 || gi == CH_CPU1) ? CPU_DIV :
                       (gi == CH_SHARED)                 ? SHARED_DIV :
                       (gi >= CH_PCI0)                   ? PCI_DIV : SRC_DIV;
    localparam bit IS_DIFF = DIFF_MASK[gi];

    clk_stop_chan #(.DIV(D), .DIFF(IS_DIFF)) chan_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .runReq    (cmd.runReq[gi]),
      .parkHiReq (cmd.parkHiReq[gi]),
      .outTrue   (clkTrue[gi]),
      .outComp   (clkComp[gi])
    );
  end
endmodule

// File: rtl/clk_stop_gen.sv
module clk_stop_gen
  import clk_stop_pkg::*;
#(
  parameter int CPU_DIV     = 3,
  parameter int SHARED_DIV  = 4,
  parameter int SRC_DIV     = 4,
  parameter int PCI_DIV     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuStopN,
  input  logic              pciSrcStopN,
  input  logic [NREQ-1:0]   clkReqN,
  input  logic              sharedIsCpu,
  input  logic [NCH-1:0]    outEnable,
  input  logic [NCH-1:0]    stopAllowed,
  input  logic [NROUTE-1:0] reqRoute,
  output logic [NCH-1:0]    clkTrue,
  output logic [NCH-1:0]    clkComp
);
  gate_cmd_t cmd;

  clk_stop_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpuStopN    (cpuStopN),
    .pciSrcStopN (pciSrcStopN),
    .clkReqN     (clkReqN),
    .sharedIsCpu (sharedIsCpu),
    .outEnable   (outEnable),
    .stopAllowed (stopAllowed),
    .reqRoute    (reqRoute),
    .cmd         (cmd)
  );

  clk_stop_dpath #(
    .CPU_DIV(CPU_DIV), .SHARED_DIV(SHARED_DIV), .SRC_DIV(SRC_DIV), .PCI_DIV(PCI_DIV)
  ) dpath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .clkTrue (clkTrue),
    .clkComp (clkComp)
  );
endmodule

// File: tb/clk_stop_gen_tb_top.sv
module clk_stop_gen_tb_top;
  localparam int E_RUN = 0;
  localparam int E_HI  = 1;
  localparam int E_LO  = 2;
  localparam int WIN   = 48;
  localparam int SETTLE = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpuStopN, pciSrcStopN, sharedIsCpu;
  logic [2:0] clkReqN;
  logic [7:0] outEnable, stopAllowed, clkTrue, clkComp;
  logic [5:0] reqRoute;

  always #4 clk = ~clk;

  clk_stop_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cpuStopN(cpuStopN), .pciSrcStopN(pciSrcStopN),
    .clkReqN(clkReqN), .sharedIsCpu(sharedIsCpu), .outEnable(outEnable),
    .stopAllowed(stopAllowed), .reqRoute(reqRoute), .clkTrue(clkTrue), .clkComp(clkComp)
  );

  int    checks = 0;
  int    fails  = 0;
  int    qCh[$];
  int    qExp[$];
  string qTag[$];
  bit    busy = 1'b0;

  function automatic int divOf(int ch);
    if (ch < 2) return 3;
    if (ch < 6) return 4;
    return 12;
  endfunction

  function automatic string modeName(int m);
    case (m)
      E_RUN:   return "RUN";
      E_HI:    return "PARK_HI";
      E_LO:    return "PARK_LO";
      default: return "BROKEN";
    endcase
  endfunction

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic apply(input logic [7:0] en, input logic [7:0] sa, input logic [5:0] rt,
                       input logic [2:0] rq, input logic cpuN, input logic pciN, input logic shr);
    outEnable = en; stopAllowed = sa; reqRoute = rt; clkReqN = rq;
    cpuStopN = cpuN; pciSrcStopN = pciN; sharedIsCpu = shr;
  endtask

  // driver: waits the latency bound, then queues one expectation per channel
  task automatic expect_all(input string tag, input int ev [8]);
    repeat (SETTLE) @(negedge clk);
    for (int ch = 0; ch < 8; ch++) begin
      qCh.push_back(ch);
      qExp.push_back(ev[ch]);
      qTag.push_back(tag);
    end
    while (qCh.size() != 0 || busy) @(negedge clk);
  endtask

  // monitor: pops one expectation and classifies the channel over a window
  initial begin
    int ch, ex, obs, changes;
    string tg;
    logic lastT, cmpBad;
    forever begin
      while (qCh.size() == 0) @(negedge clk);
      busy = 1'b1;
      ch = qCh.pop_front();
      ex = qExp.pop_front();
      tg = qTag.pop_front();
      lastT = clkTrue[ch];
      changes = 0;
      cmpBad = 1'b0;
      for (int k = 0; k < WIN; k++) begin
        @(negedge clk);
        if (clkTrue[ch] != lastT) changes++;
        lastT = clkTrue[ch];
        if (ch < 6) begin
          if (clkComp[ch] !== ~clkTrue[ch]) cmpBad = 1'b1;
        end else begin
          if (clkComp[ch] !== 1'b0) cmpBad = 1'b1;
        end
      end
      if (changes >= 2 && !cmpBad)                      obs = E_RUN;
      else if (changes == 0 && lastT && !clkComp[ch])   obs = E_HI;
      else if (changes == 0 && !lastT && !clkComp[ch])  obs = E_LO;
      else                                              obs = 3;
      checks++;
      if (obs != ex) begin
        fails++;
        $display("FAIL %s ch%0d: actual %s expected %s", tg, ch, modeName(obs), modeName(ex));
      end
      busy = 1'b0;
    end
  end

  // R3: every clkTrue segment at least one channel divisor long
  int   segLen [8];
  logic prevT  [8];
  bit   started[8];
  always @(negedge clk) begin
    for (int ch = 0; ch < 8; ch++) begin
      if (!rst_n) begin
        segLen[ch] = 0; prevT[ch] = 1'b0; started[ch] = 1'b0;
      end else if (clkTrue[ch] != prevT[ch]) begin
        if (started[ch]) begin
          checks++;
          if (segLen[ch] < divOf(ch)) begin
            fails++;
            $display("FAIL R3 ch%0d pulse width: actual %0d expected >= %0d", ch, segLen[ch], divOf(ch));
          end
        end
        started[ch] = 1'b1;
        segLen[ch] = 1;
        prevT[ch] = clkTrue[ch];
      end else begin
        segLen[ch]++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report_end();
  end

  initial begin
    rst_n = 1'b0;
    apply(8'hFF, 8'h00, 6'h00, 3'b111, 1'b1, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    checks++;
    if (clkTrue !== 8'h00 || clkComp !== 8'h00) begin
      fails++;
      $display("FAIL R1 in reset: actual %h/%h expected 00/00", clkTrue, clkComp);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (clkTrue !== 8'h00 || clkComp !== 8'h00) begin
      fails++;
      $display("FAIL R1 after release: actual %h/%h expected 00/00", clkTrue, clkComp);
    end

    expect_all("R2 R10 all free", '{E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN});

    apply(8'hFF, 8'hFF, 6'h00, 3'b111, 1'b0, 1'b1, 1'b0);
    expect_all("R4 cpu stop", '{E_HI, E_HI, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN});

    apply(8'hFF, 8'hFF, 6'h00, 3'b111, 1'b1, 1'b1, 1'b0);
    expect_all("R6 cpu resume", '{E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN});

    apply(8'hFF, 8'hFF, 6'h00, 3'b111, 1'b1, 1'b0, 1'b0);
    expect_all("R5 src/pci stop", '{E_RUN, E_RUN, E_HI, E_HI, E_HI, E_HI, E_LO, E_LO});

    apply(8'hFF, 8'hFF, 6'h00, 3'b111, 1'b1, 1'b1, 1'b0);
    expect_all("R6 src/pci resume", '{E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN});

    apply(8'hFF, 8'h00, 6'h00, 3'b111, 1'b0, 1'b0, 1'b0);
    expect_all("R10 stops ignored", '{E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN});

    apply(8'b0101_0101, 8'h00, 6'h00, 3'b111, 1'b1, 1'b1, 1'b0);
    expect_all("R7 disabled low", '{E_RUN, E_LO, E_RUN, E_LO, E_RUN, E_LO, E_RUN, E_LO});

    apply(8'b0101_0101, 8'hFF, 6'h00, 3'b111, 1'b0, 1'b0, 1'b0);
    expect_all("R7 disable over stop", '{E_HI, E_LO, E_HI, E_LO, E_HI, E_LO, E_LO, E_LO});

    apply(8'hFF, 8'h00, 6'b000001, 3'b110, 1'b1, 1'b1, 1'b0);
    expect_all("R8 req0 to src0", '{E_RUN, E_RUN, E_RUN, E_HI, E_RUN, E_RUN, E_RUN, E_RUN});

    apply(8'hFF, 8'h00, 6'b000010, 3'b110, 1'b1, 1'b1, 1'b0);
    expect_all("R8 req0 to src1 only", '{E_RUN, E_RUN, E_RUN, E_RUN, E_HI, E_RUN, E_RUN, E_RUN});

    apply(8'hFF, 8'h00, 6'b100000, 3'b011, 1'b1, 1'b1, 1'b0);
    expect_all("R8 req2 to shared", '{E_RUN, E_RUN, E_HI, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN});

    apply(8'hFF, 8'h00, 6'b100000, 3'b011, 1'b1, 1'b1, 1'b1);
    expect_all("R9 cpu-mode req immune", '{E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN});

    apply(8'hFF, 8'b0000_0100, 6'h00, 3'b111, 1'b0, 1'b1, 1'b1);
    expect_all("R9 shared follows cpu stop", '{E_RUN, E_RUN, E_HI, E_RUN, E_RUN, E_RUN, E_RUN, E_RUN});

    apply(8'hFF, 8'hFF, 6'h00, 3'b111, 1'b1, 1'b0, 1'b1);
    expect_all("R9 cpu-mode ignores src stop", '{E_RUN, E_RUN, E_RUN, E_HI, E_HI, E_HI, E_LO, E_LO});

    apply(8'hFF, 8'hFF, 6'h00, 3'b111, 1'b1, 1'b0, 1'b0);
    expect_all("R9 src-mode follows src stop", '{E_RUN, E_RUN, E_HI, E_HI, E_HI, E_HI, E_LO, E_LO});

    report_end();
  end
endmodule